// File: doc/BRIEF.md
# Coarse Early Depth Reject

This block sits between rasterisation and pixel shading. It keeps a small summary of the depth buffer that holds a single farthest depth for each 16x16 pixel screen tile. Each arriving pixel tile carries the nearest depth it can produce. If that depth is not closer than the farthest depth already stored for the tile, nothing in the tile can become visible, so the tile is dropped before any shading work is spent on it. The test runs before the fine per-sample depth test, on front-facing primitives that have already been culled in screen space.

The rejection is conservative, so a tile that passes always goes on to shading. If the shader writes its own depth, the incoming depth cannot be trusted, and the tile passes without a test. A separate write port replaces a tile's stored farthest depth whenever later stages tighten it. A clear input returns every tile to the far plane. The tile storage is indexed by the bit-interleaved (Morton) code of the tile coordinates. One decision can be issued per clock, which covers up to 256 pixels per clock.

Top module: `zcull_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `resultValid` is 0. After reset every tile holds the far value (all ones), so a test with minimum depth 0 passes.
- R2: A test issued with `testValid` high in cycle t produces `resultValid` high in cycle t+1. With `testValid` low in cycle t, `resultValid` is low in cycle t+1.
- R3: When the shader does not write depth, `resultPass` is 1 if the test's minimum depth is strictly less than the tile's stored maximum, and 0 (reject) if it is greater than or equal to it. An all-ones minimum depth is therefore always rejected.
- R4: A test with `shaderWritesDepth` high always yields `resultPass` = 1, whatever the depths.
- R5: An update with `updValid` high in cycle t replaces the addressed tile's stored maximum. Tests issued in cycle t+1 or later see the new value.
- R6: A test and an update to the same tile in the same cycle: the test is decided against the value held before the update.
- R7: `clearReq` in cycle t resets every tile to the far value from cycle t+1 on. A test in cycle t still sees the old values. An update issued in the same cycle as a clear is dropped.
- R8: An update changes only the tile whose coordinates it carries. Every other tile keeps its value, because distinct (x, y) pairs map to distinct interleaved indices (bit 2k is x bit k, bit 2k+1 is y bit k).
- R9: While `updValid` is low, the update address and data have no effect on any stored maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clearReq | input | 1 | Reset all tiles to the far value |
| testValid | input | 1 | A tile test is issued this cycle |
| testTileX | input | TILE_LOG2 | Tile column of the test |
| testTileY | input | TILE_LOG2 | Tile row of the test |
| testMinDepth | input | DEPTH_W | Nearest depth of the incoming tile |
| shaderWritesDepth | input | 1 | Shader modifies depth; bypass the test |
| updValid | input | 1 | Update of a stored tile maximum this cycle |
| updTileX | input | TILE_LOG2 | Tile column of the update |
| updTileY | input | TILE_LOG2 | Tile row of the update |
| updMaxDepth | input | DEPTH_W | New farthest depth for the tile |
| resultValid | output | 1 | Decision for the previous cycle's test |
| resultPass | output | 1 | 1 = forward to shading, 0 = rejected |

## Verification
The bench builds the block with a 4x4 tile grid (TILE_LOG2 = 2) and 8-bit depths (DEPTH_W = 8). With so few tiles, random tests and updates hit the same tile often, which exercises same-cycle test/update collisions and aliasing between tiles. With 8-bit depths, random minimum depths fall on both sides of the stored maxima, and they reach equality and the all-ones far value often enough to test the greater-or-equal reject boundary.

// File: rtl/zcull_pkg.sv
package zcull_pkg;

  // Strobes from the request decoder to the tile store
  typedef struct packed {
    logic doClear;   // return every tile to far
    logic doWrite;   // replace one tile maximum
    logic doTest;    // decide one incoming tile
    logic bypass;    // pass without comparing
  } zcStrobes_t;

endpackage

// File: rtl/zcull_ctrl.sv
module zcull_ctrl
  import zcull_pkg::*;
#(
  parameter int TILE_LOG2 = 4,
  localparam int IDX_W = 2 * TILE_LOG2
) (
  input  logic                 clearReq,
  input  logic                 testValid,
  input  logic                 shaderWritesDepth,
  input  logic                 updValid,
  input  logic [TILE_LOG2-1:0] testTileX,
  input  logic [TILE_LOG2-1:0] testTileY,
  input  logic [TILE_LOG2-1:0] updTileX,
  input  logic [TILE_LOG2-1:0] updTileY,
  output zcStrobes_t           strobes,
  output logic [IDX_W-1:0]     testIdx,
  output logic [IDX_W-1:0]     writeIdx
);

  // Morton index: even bits from x, odd bits from y
  for (genvar b = 0; b < TILE_LOG2; b++) begin : g_interleave
    assign testIdx[2*b]    = testTileX[b];
    assign testIdx[2*b+1]  = testTileY[b];
    assign writeIdx[2*b]   = updTileX[b];
    assign writeIdx[2*b+1] = updTileY[b];
  end

  // Clear outranks a same-cycle update; tests are independent of both
  always_comb begin
    strobes.doClear = clearReq;
    strobes.doWrite = updValid && !clearReq;
    strobes.doTest  = testValid;
    strobes.bypass  = testValid && shaderWritesDepth;
  end

endmodule

// File: rtl/zcull_store.sv
module zcull_store
  import zcull_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int DEPTH_W = 24,
  localparam int NUM_TILES = 1 << IDX_W,
  localparam logic [DEPTH_W-1:0] FAR_DEPTH = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  zcStrobes_t         strobes,
  input  logic [IDX_W-1:0]   testIdx,
  input  logic [IDX_W-1:0]   writeIdx,
  input  logic [DEPTH_W-1:0] testMin,
  input  logic [DEPTH_W-1:0] writeMax,
  output logic               resultValid,
  output logic               resultPass
);

  logic [DEPTH_W-1:0]   maxMem [NUM_TILES];
  logic [NUM_TILES-1:0] tileLive;   // 0 means tile still holds far
  logic [DEPTH_W-1:0]   storedMax;
  logic                 passNow;

  // Read the pre-update value so that same-cycle writes are not seen
  assign storedMax = tileLive[testIdx] ? maxMem[testIdx] : FAR_DEPTH;
  assign passNow   = strobes.bypass || (testMin < storedMax);

  always_ff @(posedge clk) begin
    if (strobes.doWrite) maxMem[writeIdx] <= writeMax;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tileLive    <= '0;
      resultValid <= 1'b0;
      resultPass  <= 1'b0;
    end else begin
      if (strobes.doClear)      tileLive <= '0;
      else if (strobes.doWrite) tileLive[writeIdx] <= 1'b1;
      resultValid <= strobes.doTest;
      resultPass  <= strobes.doTest && passNow;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !resultValid);

  // R2
  result_follows_test_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doTest |=> resultValid);

  // R4
  bypass_passes_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bypass |=> resultPass);

  // R3
  far_min_rejects_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doTest && !strobes.bypass && testMin == FAR_DEPTH) |=> !resultPass);

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doClear |=> (tileLive == '0));

  // R8
  single_tile_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doWrite && !strobes.doClear) |=>
      ($countones(tileLive) <= $past($countones(tileLive)) + 1));

endmodule

// File: rtl/zcull_top.sv
module zcull_top
  import zcull_pkg::*;
#(
  parameter int TILE_LOG2 = 4,
  parameter int DEPTH_W   = 24,
  localparam int IDX_W = 2 * TILE_LOG2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clearReq,
  input  logic                 testValid,
  input  logic [TILE_LOG2-1:0] testTileX,
  input  logic [TILE_LOG2-1:0] testTileY,
  input  logic [DEPTH_W-1:0]   testMinDepth,
  input  logic                 shaderWritesDepth,
  input  logic                 updValid,
  input  logic [TILE_LOG2-1:0] updTileX,
  input  logic [TILE_LOG2-1:0] updTileY,
  input  logic [DEPTH_W-1:0]   updMaxDepth,
  output logic                 resultValid,
  output logic                 resultPass
);

  zcStrobes_t       strobes;
  logic [IDX_W-1:0] testIdx;
  logic [IDX_W-1:0] writeIdx;

  zcull_ctrl #(.TILE_LOG2(TILE_LOG2)) u_ctrl (
    .clearReq          (clearReq),
    .testValid         (testValid),
    .shaderWritesDepth (shaderWritesDepth),
    .updValid          (updValid),
    .testTileX         (testTileX),
    .testTileY         (testTileY),
    .updTileX          (updTileX),
    .updTileY          (updTileY),
    .strobes           (strobes),
    .testIdx           (testIdx),
    .writeIdx          (writeIdx)
  );

  zcull_store #(.IDX_W(IDX_W), .DEPTH_W(DEPTH_W)) u_store (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .testIdx     (testIdx),
    .writeIdx    (writeIdx),
    .testMin     (testMinDepth),
    .writeMax    (updMaxDepth),
    .resultValid (resultValid),
    .resultPass  (resultPass)
  );

endmodule

// File: tb/tb_zcull_top.sv
`timescale 1ns/1ps
module tb_zcull_top;

  localparam int TL = 2;
  localparam int DW = 8;
  localparam int NT = 1 << (2 * TL);
  localparam int FARV = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearReq = 1'b0;
  logic testValid = 1'b0;
  logic [TL-1:0] testTileX = '0, testTileY = '0;
  logic [DW-1:0] testMinDepth = '0;
  logic shaderWritesDepth = 1'b0;
  logic updValid = 1'b0;
  logic [TL-1:0] updTileX = '0, updTileY = '0;
  logic [DW-1:0] updMaxDepth = '0;
  logic resultValid, resultPass;

  int checks = 0;
  int errors = 0;
  int model [NT];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  zcull_top #(.TILE_LOG2(TL), .DEPTH_W(DW)) dut (
    .clk(clk), .rstN(rstN), .clearReq(clearReq),
    .testValid(testValid), .testTileX(testTileX), .testTileY(testTileY),
    .testMinDepth(testMinDepth), .shaderWritesDepth(shaderWritesDepth),
    .updValid(updValid), .updTileX(updTileX), .updTileY(updTileY),
    .updMaxDepth(updMaxDepth), .resultValid(resultValid), .resultPass(resultPass)
  );

  function automatic int tileIndex(int x, int y);
    return y * (1 << TL) + x;   // model index; any unique mapping works
  endfunction

  function automatic bit expectPass(int x, int y, int minD, bit wd);
    return wd || (minD < model[tileIndex(x, y)]);
  endfunction

  task automatic check(string tag, bit actV, bit expV, bit actP, bit expP);
    checks++;
    if (actV !== expV || (expV && actP !== expP)) begin
      errors++;
      $display("FAIL %s valid=%0b pass=%0b expected valid=%0b pass=%0b",
               tag, actV, actP, expV, expP);
    end
  endtask

  // One cycle: drive at negedge, update model, check at next negedge
  task automatic step(bit tv, int tx, int ty, int tmin, bit wd,
                      bit uv, int ux, int uy, int umax, bit clr, string tag);
    bit ep;
    testValid = tv; testTileX = TL'(tx); testTileY = TL'(ty);
    testMinDepth = DW'(tmin); shaderWritesDepth = wd;
    updValid = uv; updTileX = TL'(ux); updTileY = TL'(uy);
    updMaxDepth = DW'(umax); clearReq = clr;
    ep = expectPass(tx, ty, tmin, wd);
    if (clr) begin
      for (int i = 0; i < NT; i++) model[i] = FARV;
    end else if (uv) begin
      model[tileIndex(ux, uy)] = umax;
    end
    @(negedge clk);
    check(tag, resultValid, tv, resultPass, ep);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < NT; i++) model[i] = FARV;

    repeat (3) @(negedge clk);
    checks++;
    if (resultValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 valid=%0b expected 0 in reset", resultValid);
    end
    rstN = 1'b1;
    checks++;
    if (resultValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 valid=%0b expected 0 after reset", resultValid);
    end
    // R1: fresh tiles are far, min 0 passes; R3: all-ones min rejected
    step(1, 1, 2, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 1, 2, FARV, 0, 0, 0, 0, 0, 0, "R3");
    idle("R2");
    // R5 then R3 boundary: equal rejects, one below passes
    step(0, 0, 0, 0, 0, 1, 3, 1, 100, 0, "R5");
    step(1, 3, 1, 100, 0, 0, 0, 0, 0, 0, "R3");
    step(1, 3, 1, 99, 0, 0, 0, 0, 0, 0, "R3");
    step(1, 3, 1, 200, 0, 0, 0, 0, 0, 0, "R5");
    // R4: bypass passes even above stored max
    step(1, 3, 1, FARV, 1, 0, 0, 0, 0, 0, "R4");
    // R8: x/y swapped tile and neighbour untouched
    step(1, 1, 3, 200, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 2, 1, 200, 0, 0, 0, 0, 0, 0, "R8");
    // R6: same-cycle update to 10 not seen; next cycle sees it
    step(1, 3, 1, 50, 0, 1, 3, 1, 10, 0, "R6");
    step(1, 3, 1, 50, 0, 0, 0, 0, 0, 0, "R6");
    // R9: disabled update carries data but has no effect
    testValid = 0; updValid = 0; updTileX = 3; updTileY = 1; updMaxDepth = 250;
    @(negedge clk);
    step(1, 3, 1, 50, 0, 0, 0, 0, 0, 0, "R9");
    // R7: test in clear cycle sees old; clear beats update
    step(1, 3, 1, 50, 0, 1, 0, 0, 5, 1, "R7");
    step(1, 3, 1, 50, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 0, 0, 50, 0, 0, 0, 0, 0, 0, "R7");

    for (int n = 0; n < 4000; n++) begin
      bit tv, wd, uv, clr;
      int tx, ty, tm, ux, uy, um;
      tv = ($urandom % 4) != 0;
      wd = ($urandom % 10) == 0;
      uv = ($urandom % 3) == 0;
      clr = ($urandom % 100) == 0;
      tx = $urandom % (1 << TL); ty = $urandom % (1 << TL);
      ux = $urandom % (1 << TL); uy = $urandom % (1 << TL);
      tm = $urandom % (FARV + 1); um = $urandom % (FARV + 1);
      if (($urandom % 8) == 0) tm = model[tileIndex(tx, ty)];
      step(tv, tx, ty, tm, wd, uv, ux, uy, um, clr, wd ? "R4" : "R3");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule